// File: doc/BRIEF.md
# Prescaled Reload Timer with Edge Capture

This block is a general-purpose timer for a small controller. A 5-bit prescaler feeds a 16-bit down-counter. Both reload from values written by software, and both run off a count tick. The tick comes from one of two sources. The first is an internal divide-by-four of the single system clock. The second is a synchronized rising edge on an external event pin. Each time the counter goes through zero, it reloads and raises a sticky interrupt flag. So the flag period is the tick period times (prescale reload + 1) times (count reload + 1).

A capture pin, synchronized and edge-detected, copies the live down-counter value into a read-only capture register. Software picks whether the rising or the falling edge is active. An idle input blocks capture while it is high. In toggle-output mode the timer owns the pin output and inverts it on every zero crossing. When software leaves that mode, the port data bit still holds the last level the timer drove, and software may change it again.

Software uses a flat byte register bus: write strobe, 3-bit address, write data, and a combinational read-data path.

Top module: `rld_timer`

## Requirements
- R1: After reset, every readable register returns 0x00, `irq_o` is low and `pin_o` is low.
- R2: Address 0 is the control register: bit0 = start (a strobe that reads back 0), bit1 = event mode, bit2 = capture on falling edge (0 selects rising), bit3 = toggle mode, bit4 = interrupt enable. Address 1 is the prescale reload (5 bits). Addresses 2 and 3 are the low and high bytes of the count reload. In internal mode, the flag sets DIV*(P+1)*(T+1) clock cycles after the clock edge that accepts a start write (DIV=4).
- R3: In event mode, each rising edge of `evt_i` is one count tick, after a two-flop synchronizer. Falling edges and steady levels do not count.
- R4: A start write reloads both the prescaler and the down-counter, and a running count starts again from the reload values. A start write never changes `pin_o`.
- R5: On the selected edge of `cap_i`, the live down-counter value is copied into the capture register, read at addresses 6 (low byte) and 7 (high byte). The other edge leaves it unchanged.
- R6: While `idle_i` is high, capture edges leave the capture register unchanged.
- R7: Address 4 bit0 is the interrupt flag. A zero crossing sets it. It stays set until software writes 1 to that bit, and writing 0 leaves it alone. `irq_o` is high only when both the flag and the enable bit are set.
- R8: In toggle mode, `pin_o` inverts on every zero crossing, whatever the interrupt enable is. Writes to the port data bit (address 5 bit0) do not change it.
- R9: Outside toggle mode, address 5 bit0 drives `pin_o` and reads back the last level the pin had, including the level the timer left when toggle mode ended.
- R10: The capture register is read-only: writes to addresses 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| evt_i | input | 1 | External event pin (asynchronous) |
| cap_i | input | 1 | Capture pin (asynchronous) |
| idle_i | input | 1 | Idle state; blocks capture while high |
| irq_o | output | 1 | Interrupt request |
| pin_o | output | 1 | Port pin output |

## Verification
The bench builds the block with the default widths (5-bit prescaler, 16-bit counter, divide-by-four tick). It keeps the reload values small. That puts zero crossings, including the maximum prescale value of 31, within a few hundred cycles, so exact periods can be measured cycle for cycle. In event mode the counter stands still between pin pulses. This lets capture values, prescaler grouping, idle gating and edge selection be read back as exact numbers through the capture register.

// File: rtl/rld_timer_pkg.sv
// Package: shared register addresses and control bit positions for rld_timer.
// Assumes a 3-bit byte address space; all other sizing lives in module parameters.
package rld_timer_pkg;
    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_PRE   = 3'd1;
    localparam logic [2:0] A_RLD_L = 3'd2;
    localparam logic [2:0] A_RLD_H = 3'd3;
    localparam logic [2:0] A_STAT  = 3'd4;
    localparam logic [2:0] A_PORT  = 3'd5;
    localparam logic [2:0] A_CAP_L = 3'd6;
    localparam logic [2:0] A_CAP_H = 3'd7;

    localparam int B_START = 0;
    localparam int B_EVT   = 1;
    localparam int B_FALL  = 2;
    localparam int B_TOG   = 3;
    localparam int B_IEN   = 4;

    typedef struct packed {
        logic irq_en;
        logic tog_en;
        logic cap_fall;
        logic evt_mode;
    } ctrl_t;
endpackage

// File: rtl/rld_sync_edge.sv
// Module: synchronizes an asynchronous pin and flags its rising and falling edges.
// Assumes each pin level lasts at least two clock cycles; edges are one-cycle pulses.
module rld_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the pin through the synchronizer chain and keep the last settled level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Compare settled level against its previous value.
    always_comb begin
        rise = sync_q[STAGES-1] & ~prev_q;
        fall = ~sync_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/rld_tick_gen.sv
// Module: produces the count tick from an internal divider or external event edges.
// Assumes start restarts the divider phase; no tick before the first start.
module rld_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic evt_mode,
    input  logic evt_rise,
    output logic tick
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

    logic             run_q;
    logic [DIV_W-1:0] div_q;

    // Track run state and advance the internal divider while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            div_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            div_q <= '0;
        end else if (run_q) begin
            div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
        end
    end

    // Select the tick source.
    always_comb begin
        if (!run_q || start) tick = 1'b0;
        else if (evt_mode)   tick = evt_rise;
        else                 tick = (div_q == DIV_LAST);
    end
endmodule

// File: rtl/rld_count_chain.sv
// Module: prescaler plus reloading down-counter; flags the tick that passes zero.
// Assumes start has priority over tick; reload values are sampled when used.
module rld_count_chain #(
    parameter int PRE_W = 5,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  logic [PRE_W-1:0] pre_rld,
    input  logic [CNT_W-1:0] cnt_rld,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;

    // Reload on start, otherwise step the prescaler and the counter on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (start) begin
            pre_q <= pre_rld;
            cnt_q <= cnt_rld;
        end else if (tick) begin
            if (pre_q == '0) begin
                pre_q <= pre_rld;
                cnt_q <= (cnt_q == '0) ? cnt_rld : cnt_q - 1'b1;
            end else begin
                pre_q <= pre_q - 1'b1;
            end
        end
    end

    // Zero crossing: both stages at zero on a live tick.
    always_comb begin
        wrap = tick & ~start & (pre_q == '0) & (cnt_q == '0);
        cnt  = cnt_q;
    end
endmodule

// File: rtl/rld_timer.sv
// Module: top of the prescaled reload timer: registers, capture, flag and pin logic.
// Assumes a single clock, synchronous active-low reset, byte registers per rld_timer_pkg.
module rld_timer
    import rld_timer_pkg::*;
#(
    parameter int PRE_W = 5,
    parameter int CNT_W = 16,
    parameter int DIV   = 4,
    parameter int SYNC  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       evt_i,
    input  logic       cap_i,
    input  logic       idle_i,
    output logic       irq_o,
    output logic       pin_o
);
    localparam int CAP_PAD = 16 - CNT_W;

    ctrl_t            ctrl_q;
    logic [PRE_W-1:0] pre_rld_q;
    logic [15:0]      cnt_rld_q;
    logic [CNT_W-1:0] cap_q;
    logic [CNT_W-1:0] cnt;
    logic [15:0]      cap_w;
    logic             flag_q;
    logic             pin_q;
    logic             start, clr_wr, port_wr;
    logic             evt_rise, evt_fall, cap_rise, cap_fall_e;
    logic             tick, wrap, cap_hit;

    // Decode write strobes with side effects.
    always_comb begin
        start   = wr_en && (addr == A_CTRL) && wdata[B_START];
        clr_wr  = wr_en && (addr == A_STAT) && wdata[0];
        port_wr = wr_en && (addr == A_PORT);
        cap_hit = !idle_i && (ctrl_q.cap_fall ? cap_fall_e : cap_rise);
    end

    rld_sync_edge #(.STAGES(SYNC)) u_evt (
        .clk(clk), .rst_n(rst_n), .pin(evt_i), .rise(evt_rise), .fall(evt_fall));

    rld_sync_edge #(.STAGES(SYNC)) u_cap (
        .clk(clk), .rst_n(rst_n), .pin(cap_i), .rise(cap_rise), .fall(cap_fall_e));

    rld_tick_gen #(.DIV(DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .start(start), .evt_mode(ctrl_q.evt_mode),
        .evt_rise(evt_rise), .tick(tick));

    rld_count_chain #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chain (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
        .pre_rld(pre_rld_q), .cnt_rld(cnt_rld_q[CNT_W-1:0]), .cnt(cnt), .wrap(wrap));

    // Software-writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            pre_rld_q <= '0;
            cnt_rld_q <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL:  ctrl_q    <= ctrl_t'({wdata[B_IEN], wdata[B_TOG], wdata[B_FALL], wdata[B_EVT]});
                A_PRE:   pre_rld_q <= wdata[PRE_W-1:0];
                A_RLD_L: cnt_rld_q[7:0]  <= wdata;
                A_RLD_H: cnt_rld_q[15:8] <= wdata;
                default: ;
            endcase
        end
    end

    // Sticky interrupt flag: a zero crossing wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (wrap)   flag_q <= 1'b1;
        else if (clr_wr) flag_q <= 1'b0;
    end

    // Pin level register, shared by toggle mode and the port data bit.
    always_ff @(posedge clk) begin
        if (!rst_n)              pin_q <= 1'b0;
        else if (ctrl_q.tog_en)  pin_q <= pin_q ^ wrap;
        else if (port_wr)        pin_q <= wdata[0];
    end

    // Capture the live count on the selected edge unless idle.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (cap_hit) cap_q <= cnt;
    end

    // Read mux and outputs.
    always_comb begin
        cap_w = {{CAP_PAD{1'b0}}, cap_q};
        case (addr)
            A_CTRL:  rdata = {3'b000, ctrl_q.irq_en, ctrl_q.tog_en, ctrl_q.cap_fall, ctrl_q.evt_mode, 1'b0};
            A_PRE:   rdata = 8'(pre_rld_q);
            A_RLD_L: rdata = cnt_rld_q[7:0];
            A_RLD_H: rdata = cnt_rld_q[15:8];
            A_STAT:  rdata = {7'b0, flag_q};
            A_PORT:  rdata = {7'b0, pin_q};
            A_CAP_L: rdata = cap_w[7:0];
            default: rdata = cap_w[15:8];
        endcase
        irq_o = flag_q & ctrl_q.irq_en;
        pin_o = pin_q;
    end

    logic unused_ok;
    assign unused_ok = evt_fall;
endmodule

// File: rtl/rld_timer_chk.sv
// Checker: temporal properties of rld_timer, attached by bind below.
// Assumes access to the zero-crossing pulse, flag and capture state of the top.
module rld_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wrap,
    input logic             start,
    input logic             clr_wr,
    input logic             tog_en,
    input logic             pin_o,
    input logic             idle_i,
    input logic             flag_q,
    input logic             irq_o,
    input logic [CNT_W-1:0] cap_q
);
    // R7: a zero crossing leaves the flag set on the next cycle.
    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag_q);

    // R7: the flag holds without a clear write.
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_wr) |=> flag_q);

    // R7: the request line never rises without the flag.
    p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_q);

    // R8: in toggle mode a zero crossing inverts the pin.
    p_pin_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_en && wrap) |=> (pin_o != $past(pin_o)));

    // R8: in toggle mode the pin holds between zero crossings.
    p_pin_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_en && !wrap) |=> $stable(pin_o));

    // R4: a start write never moves the pin.
    p_start_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && tog_en) |=> $stable(pin_o));

    // R6: idle freezes the capture register.
    p_idle_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idle_i |=> $stable(cap_q));
endmodule

bind rld_timer rld_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .start(start), .clr_wr(clr_wr),
    .tog_en(ctrl_q.tog_en), .pin_o(pin_o), .idle_i(idle_i), .flag_q(flag_q),
    .irq_o(irq_o), .cap_q(cap_q));

// File: tb/rld_timer_tb_top.sv
// Bench: table-driven period measurement, then directed tests for modes and corners.
module rld_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       evt_i = 1'b0, cap_i = 1'b0, idle_i = 1'b0;
    logic       irq_o, pin_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    rld_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .evt_i(evt_i), .cap_i(cap_i), .idle_i(idle_i),
        .irq_o(irq_o), .pin_o(pin_o));

    // Each entry: {prescale reload[7:0], count reload[15:0]}.
    localparam logic [23:0] VEC [6] = '{
        {8'd0, 16'd0}, {8'd1, 16'd0}, {8'd0, 16'd3},
        {8'd3, 16'd2}, {8'd31, 16'd1}, {8'd2, 16'd9}};

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        addr = a; #1; v = int'(rdata);
    endtask

    task automatic cyc(input int k);
        for (int i = 0; i < k; i++) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic evt_pulse();
        evt_i = 1'b1; cyc(3); evt_i = 1'b0; cyc(3);
    endtask

    task automatic cap_to(input logic lv);
        cap_i = lv; cyc(4);
    endtask

    task automatic rd_cap(output int v);
        int lo, hi;
        rd(3'd6, lo); rd(3'd7, hi); v = (hi << 8) | lo;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v, n, exp;
        cyc(3); rst_n = 1'b1; cyc(1);
        // R1: reset state
        for (int a = 0; a < 8; a++) begin rd(3'(a), v); check("R1 reg", v, 0); end
        check("R1 irq", int'(irq_o), 0);
        check("R1 pin", int'(pin_o), 0);

        // R2: table of period measurements in internal mode with interrupt enabled
        for (int k = 0; k < 6; k++) begin
            wr(3'd1, VEC[k][23:16]);
            wr(3'd2, VEC[k][7:0]);
            wr(3'd3, VEC[k][15:8]);
            wr(3'd0, 8'h11);
            wr(3'd4, 8'h01);
            n = 1;
            while (!irq_o && n < 2000) begin @(posedge clk); n++; @(negedge clk); end
            exp = 4 * (int'(VEC[k][23:16]) + 1) * (int'(VEC[k][15:0]) + 1);
            check("R2 period", n, exp);
        end

        // R7: writing 0 keeps the flag, writing 1 clears it, enable gates irq_o
        wr(3'd0, 8'h02);                      // event mode, no start: chain frozen
        wr(3'd4, 8'h00);
        rd(3'd4, v); check("R7 keep on write 0", v, 1);
        check("R7 irq gated off", int'(irq_o), 0);
        wr(3'd4, 8'h01);
        rd(3'd4, v); check("R7 clear", v, 0);

        // R9: port data drives the pin outside toggle mode
        wr(3'd5, 8'h01);
        check("R9 port drives pin", int'(pin_o), 1);

        // R8/R4: toggle mode, irq disabled, period 40 cycles
        wr(3'd1, 8'd0); wr(3'd2, 8'd9); wr(3'd3, 8'd0);
        wr(3'd0, 8'h09);                      // start + toggle
        cyc(3);
        check("R4 start no toggle", int'(pin_o), 1);
        wr(3'd5, 8'h00);                      // ignored in toggle mode
        check("R8 port write ignored", int'(pin_o), 1);
        cyc(35);
        check("R8 before crossing", int'(pin_o), 1);
        cyc(1);
        check("R8 toggled at crossing", int'(pin_o), 0);
        rd(3'd4, v); check("R8 flag without enable", v, 1);
        check("R8 irq stays low", int'(irq_o), 0);
        wr(3'd0, 8'h02);                      // leave toggle mode, freeze chain
        rd(3'd5, v); check("R9 last timer level", v, 0);
        wr(3'd5, 8'h01);
        check("R9 cpu owns pin again", int'(pin_o), 1);

        // R3/R5: event mode capture, rising select
        wr(3'd1, 8'd0); wr(3'd2, 8'd5);
        wr(3'd0, 8'h03);                      // start in event mode
        cap_to(1'b1);
        rd_cap(v); check("R5 rising capture", v, 5);
        evt_pulse(); evt_pulse();
        cap_to(1'b0);
        rd_cap(v); check("R5 falling ignored", v, 5);
        wr(3'd0, 8'h06);                      // falling select
        cap_to(1'b1);
        rd_cap(v); check("R5 rising ignored", v, 5);
        cap_to(1'b0);
        rd_cap(v); check("R3 two events counted", v, 3);

        // R6: idle blocks capture
        idle_i = 1'b1;
        evt_pulse();
        cap_to(1'b1); cap_to(1'b0);
        rd_cap(v); check("R6 idle blocks", v, 3);
        idle_i = 1'b0;
        cap_to(1'b1); cap_to(1'b0);
        rd_cap(v); check("R6 resumes after idle", v, 2);

        // R10: capture register is read-only
        wr(3'd6, 8'hAA); wr(3'd7, 8'h55);
        rd_cap(v); check("R10 read-only", v, 2);

        // R3/R4: prescaler groups events; start reloads a running chain
        wr(3'd1, 8'd2); wr(3'd2, 8'd4);
        wr(3'd0, 8'h07);
        evt_pulse(); evt_pulse();
        cap_to(1'b1); cap_to(1'b0);
        rd_cap(v); check("R3 prescaler holds count", v, 4);
        evt_pulse();
        cap_to(1'b1); cap_to(1'b0);
        rd_cap(v); check("R3 third event steps count", v, 3);
        wr(3'd0, 8'h07);
        cap_to(1'b1); cap_to(1'b0);
        rd_cap(v); check("R4 restart reloads", v, 4);

        // R3: event mode zero crossing after (P+1)*(T+1) events
        wr(3'd4, 8'h01);
        wr(3'd1, 8'd0); wr(3'd2, 8'd1);
        wr(3'd0, 8'h13);
        evt_pulse();
        check("R3 no flag after one event", int'(irq_o), 0);
        evt_pulse();
        check("R3 flag after two events", int'(irq_o), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule